// File: doc/BRIEF.md
# Error Event Monitor with Masked Pulses and Error Counting

This block watches two groups of per-cycle error event lines. Every event bit is captured into a sticky flag that holds until hard reset. Each group has two masks of its own. The error mask decides whether an event raises the one-cycle error pulse and counts as an error. The trigger mask independently decides whether the same event raises the one-cycle trigger pulse. In both masks a set bit suppresses the matching event.

Three summary levels are derived from the sticky flags. The first shows any captured flag regardless of masks. The second shows any flag that the current error mask lets through. The third shows any flag that the current trigger mask lets through. A saturating counter records the cycles in which an error got through, and a sticky status bit rises once the count reaches a programmable 4-bit limit.

A small register port gives read access to flags, masks, count, limit and status, and write access to the masks and the limit. The reset is asynchronous and active-low, and the block releases it internally through a two-stage synchronizer. Stimulus should therefore start at least three clock cycles after reset is released.

Top module: `err_event_monitor`

## Requirements
- R1: Each event bit sets its flag on the clock edge where it is high. A flag stays set until hard reset. Flags read at address 0 (group A, 32 bits) and address 1 (group B, 20 bits), and writes to those addresses change nothing.
- R2: The error pulse is high for exactly the one cycle after an edge on which at least one event bit had a clear error-mask bit. Any number of such bits in one cycle give a single pulse.
- R3: The trigger pulse follows the same timing but uses the trigger mask, independently of the error mask.
- R4: After reset, all flags and the count are 0. The error and trigger masks of group A are 0x01FFE000, those of group B are 0x000E087C, and the limit is 0xF.
- R5: Status bit 0 is set when any flag is set. Bit 1 is set when any flag has a clear error-mask bit, and bit 2 when any flag has a clear trigger-mask bit. These bits follow mask changes at once.
- R6: The count (address 6) increases by one for each cycle that produces an error pulse and saturates at 0xFFFF. Writes to it are ignored.
- R7: The limit (address 7, bits 3:0, upper bits read 0) is read-write. Status bit 3 becomes set one cycle after the count is nonzero and at or above the limit, and stays set until hard reset.
- R8: An event in the same cycle as a mask write is judged against the mask value before the write. The new value applies from the next cycle.
- R9: Address map: error masks at 2 (A) and 3 (B), trigger masks at 4 (A) and 5 (B), status at 8. Addresses 9 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| evt_a_i | input | 32 | Group A error event lines |
| evt_b_i | input | 20 | Group B error event lines |
| reg_addr_i | input | 4 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| err_pulse_o | output | 1 | One-cycle error pulse |
| trig_pulse_o | output | 1 | One-cycle trigger pulse |
| pend_raw_o | output | 1 | Any flag set |
| pend_err_o | output | 1 | Any flag passing the error mask |
| pend_trig_o | output | 1 | Any flag passing the trigger mask |
| lim_reached_o | output | 1 | Sticky count-limit status |

## Verification
A mask write and an event can fall in the same cycle. The bench drives both on one edge and expects the pulse and the count to follow the old mask, then repeats the event and expects the new mask to rule. A second collision is an error arriving while the counter is saturated, or while the limit is being lowered under the current count. The bench holds events for more than 65535 cycles, then expects the count to stay at its maximum while pulses continue. It also expects the limit status to rise one cycle after a limit write, with no further error.

// File: rtl/err_mon_pkg.sv
package err_mon_pkg;

  localparam int unsigned MAP_AW = 4;

  localparam logic [MAP_AW-1:0] ADR_FLAGS_A = 4'd0;
  localparam logic [MAP_AW-1:0] ADR_FLAGS_B = 4'd1;
  localparam logic [MAP_AW-1:0] ADR_EMASK_A = 4'd2;
  localparam logic [MAP_AW-1:0] ADR_EMASK_B = 4'd3;
  localparam logic [MAP_AW-1:0] ADR_TMASK_A = 4'd4;
  localparam logic [MAP_AW-1:0] ADR_TMASK_B = 4'd5;
  localparam logic [MAP_AW-1:0] ADR_COUNT   = 4'd6;
  localparam logic [MAP_AW-1:0] ADR_LIMIT   = 4'd7;
  localparam logic [MAP_AW-1:0] ADR_STATUS  = 4'd8;

  // status word, bit 0 is pend_raw
  typedef struct packed {
    logic lim_reached;
    logic pend_trig;
    logic pend_err;
    logic pend_raw;
  } mon_status_t;

endpackage

// File: rtl/err_evt_group.sv
module err_evt_group #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] EMASK_RST = '0,
  parameter logic [W-1:0] TMASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         emask_we_i,
  input  logic         tmask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] emask_o,
  output logic [W-1:0] tmask_o,
  output logic         hit_err_o,
  output logic         hit_trig_o,
  output logic         pend_raw_o,
  output logic         pend_err_o,
  output logic         pend_trig_o
);

  logic [W-1:0] flags_q, flags_d;
  logic         flags_en;
  logic [W-1:0] emask_q, tmask_q;

  always_comb begin
    flags_en = |evt_i;
    flags_d  = flags_q | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emask_q <= EMASK_RST;
    end else if (emask_we_i) begin
      emask_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmask_q <= TMASK_RST;
    end else if (tmask_we_i) begin
      tmask_q <= wdata_i;
    end
  end

  always_comb begin
    hit_err_o   = |(evt_i & ~emask_q);
    hit_trig_o  = |(evt_i & ~tmask_q);
    pend_raw_o  = |flags_q;
    pend_err_o  = |(flags_q & ~emask_q);
    pend_trig_o = |(flags_q & ~tmask_q);
  end

  assign flags_o = flags_q;
  assign emask_o = emask_q;
  assign tmask_o = tmask_q;

endmodule

// File: rtl/err_evt_counter.sv
module err_evt_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LIM_W = 4,
  parameter logic [LIM_W-1:0] LIM_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             lim_we_i,
  input  logic [LIM_W-1:0] lim_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [LIM_W-1:0] lim_o,
  output logic             reached_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [LIM_W-1:0] lim_q;
  logic             reach_q, reach_d;

  always_comb begin
    cnt_en  = inc_i && (cnt_q != CNT_MAX);
    cnt_d   = cnt_q + CNT_W'(1);
    reach_d = reach_q | ((cnt_q != '0) && (cnt_q >= CNT_W'(lim_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= LIM_RST;
    end else if (lim_we_i) begin
      lim_q <= lim_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reach_q <= 1'b0;
    end else begin
      reach_q <= reach_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign lim_o     = lim_q;
  assign reached_o = reach_q;

endmodule

// File: rtl/err_evt_pulse.sv
module err_evt_pulse #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] pulse_o
);

  logic [N-1:0] pulse_q;

  for (genvar g = 0; g < N; g++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulse_q[g] <= 1'b0;
      end else begin
        pulse_q[g] <= hit_i[g];
      end
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/err_event_monitor.sv
module err_event_monitor
  import err_mon_pkg::*;
#(
  parameter int unsigned GRP_A_W = 32,
  parameter int unsigned GRP_B_W = 20,
  parameter logic [GRP_A_W-1:0] MASK_A_RST = 32'h01FF_E000,
  parameter logic [GRP_B_W-1:0] MASK_B_RST = 20'hE_087C,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LIM_W  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_A_W-1:0] evt_a_i,
  input  logic [GRP_B_W-1:0] evt_b_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              err_pulse_o,
  output logic              trig_pulse_o,
  output logic              pend_raw_o,
  output logic              pend_err_o,
  output logic              pend_trig_o,
  output logic              lim_reached_o
);

  localparam int unsigned N_PULSE = 2;
  localparam logic [LIM_W-1:0] LIM_RST = '1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  // write decode
  logic we_emask_a, we_emask_b, we_tmask_a, we_tmask_b, we_limit;
  always_comb begin
    we_emask_a = reg_we_i && (reg_addr_i == ADDR_W'(ADR_EMASK_A));
    we_emask_b = reg_we_i && (reg_addr_i == ADDR_W'(ADR_EMASK_B));
    we_tmask_a = reg_we_i && (reg_addr_i == ADDR_W'(ADR_TMASK_A));
    we_tmask_b = reg_we_i && (reg_addr_i == ADDR_W'(ADR_TMASK_B));
    we_limit   = reg_we_i && (reg_addr_i == ADDR_W'(ADR_LIMIT));
  end

  logic [GRP_A_W-1:0] flags_a, emask_a, tmask_a;
  logic [GRP_B_W-1:0] flags_b, emask_b, tmask_b;
  logic hit_err_a, hit_trig_a, raw_a, perr_a, ptrig_a;
  logic hit_err_b, hit_trig_b, raw_b, perr_b, ptrig_b;

  err_evt_group #(
    .W(GRP_A_W), .EMASK_RST(MASK_A_RST), .TMASK_RST(MASK_A_RST)
  ) u_grp_a (
    .clk(clk), .rst_n(rst_ns), .evt_i(evt_a_i),
    .emask_we_i(we_emask_a), .tmask_we_i(we_tmask_a),
    .wdata_i(reg_wdata_i[GRP_A_W-1:0]),
    .flags_o(flags_a), .emask_o(emask_a), .tmask_o(tmask_a),
    .hit_err_o(hit_err_a), .hit_trig_o(hit_trig_a),
    .pend_raw_o(raw_a), .pend_err_o(perr_a), .pend_trig_o(ptrig_a)
  );

  err_evt_group #(
    .W(GRP_B_W), .EMASK_RST(MASK_B_RST), .TMASK_RST(MASK_B_RST)
  ) u_grp_b (
    .clk(clk), .rst_n(rst_ns), .evt_i(evt_b_i),
    .emask_we_i(we_emask_b), .tmask_we_i(we_tmask_b),
    .wdata_i(reg_wdata_i[GRP_B_W-1:0]),
    .flags_o(flags_b), .emask_o(emask_b), .tmask_o(tmask_b),
    .hit_err_o(hit_err_b), .hit_trig_o(hit_trig_b),
    .pend_raw_o(raw_b), .pend_err_o(perr_b), .pend_trig_o(ptrig_b)
  );

  logic err_hit, trig_hit;
  assign err_hit  = hit_err_a | hit_err_b;
  assign trig_hit = hit_trig_a | hit_trig_b;

  logic [N_PULSE-1:0] pulses;
  err_evt_pulse #(.N(N_PULSE)) u_pulse (
    .clk(clk), .rst_n(rst_ns),
    .hit_i({trig_hit, err_hit}),
    .pulse_o(pulses)
  );

  logic [CNT_W-1:0] cnt_val;
  logic [LIM_W-1:0] lim_val;
  logic             lim_hit;

  err_evt_counter #(
    .CNT_W(CNT_W), .LIM_W(LIM_W), .LIM_RST(LIM_RST)
  ) u_cnt (
    .clk(clk), .rst_n(rst_ns), .inc_i(err_hit),
    .lim_we_i(we_limit), .lim_wdata_i(reg_wdata_i[LIM_W-1:0]),
    .cnt_o(cnt_val), .lim_o(lim_val), .reached_o(lim_hit)
  );

  mon_status_t status;
  always_comb begin
    status.pend_raw    = raw_a | raw_b;
    status.pend_err    = perr_a | perr_b;
    status.pend_trig   = ptrig_a | ptrig_b;
    status.lim_reached = lim_hit;
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_W'(ADR_FLAGS_A): reg_rdata_o = DATA_W'(flags_a);
      ADDR_W'(ADR_FLAGS_B): reg_rdata_o = DATA_W'(flags_b);
      ADDR_W'(ADR_EMASK_A): reg_rdata_o = DATA_W'(emask_a);
      ADDR_W'(ADR_EMASK_B): reg_rdata_o = DATA_W'(emask_b);
      ADDR_W'(ADR_TMASK_A): reg_rdata_o = DATA_W'(tmask_a);
      ADDR_W'(ADR_TMASK_B): reg_rdata_o = DATA_W'(tmask_b);
      ADDR_W'(ADR_COUNT):   reg_rdata_o = DATA_W'(cnt_val);
      ADDR_W'(ADR_LIMIT):   reg_rdata_o = DATA_W'(lim_val);
      ADDR_W'(ADR_STATUS):  reg_rdata_o = DATA_W'(status);
      default:              reg_rdata_o = '0;
    endcase
  end

  assign err_pulse_o   = pulses[0];
  assign trig_pulse_o  = pulses[1];
  assign pend_raw_o    = status.pend_raw;
  assign pend_err_o    = status.pend_err;
  assign pend_trig_o   = status.pend_trig;
  assign lim_reached_o = status.lim_reached;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

endmodule

// File: rtl/err_event_monitor_chk.sv
module err_event_monitor_chk #(
  parameter int unsigned GRP_A_W = 32,
  parameter int unsigned GRP_B_W = 20,
  parameter int unsigned CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [GRP_A_W-1:0] evt_a_i,
  input logic [GRP_B_W-1:0] evt_b_i,
  input logic [GRP_A_W-1:0] flags_a,
  input logic [GRP_B_W-1:0] flags_b,
  input logic [CNT_W-1:0]   cnt_val,
  input logic               err_pulse_o,
  input logic               trig_pulse_o,
  input logic               pend_raw_o,
  input logic               pend_err_o,
  input logic               pend_trig_o,
  input logic               lim_reached_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1: flags never clear while out of reset
  p_flags_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_a & $past(flags_a)) == $past(flags_a)) &&
    ((flags_b & $past(flags_b)) == $past(flags_b)));

  // R2: an error pulse needs an event on the previous edge
  p_err_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> $past((evt_a_i != '0) || (evt_b_i != '0)));

  // R3: a trigger pulse needs an event on the previous edge
  p_trig_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse_o |-> $past((evt_a_i != '0) || (evt_b_i != '0)));

  // R5: a masked-level summary implies the raw summary
  p_pend_implies_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_err_o || pend_trig_o) |-> pend_raw_o);

  // R6: count moves by at most one per cycle
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val == $past(cnt_val)) || (cnt_val == $past(cnt_val) + CNT_W'(1)));

  // R6: each error pulse matches one increment unless saturated
  p_cnt_follows_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> ((cnt_val == $past(cnt_val) + CNT_W'(1)) ||
                     ($past(cnt_val) == CNT_MAX)));

  // R6: saturation holds
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_val) == CNT_MAX) |-> (cnt_val == CNT_MAX));

  // R7: limit status is sticky
  p_lim_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lim_reached_o) |-> lim_reached_o);

  // R7: limit status needs a nonzero count
  p_lim_needs_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lim_reached_o) |-> ($past(cnt_val) != '0));

endmodule

bind err_event_monitor err_event_monitor_chk #(
  .GRP_A_W(GRP_A_W), .GRP_B_W(GRP_B_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_a_i(evt_a_i), .evt_b_i(evt_b_i),
  .flags_a(flags_a), .flags_b(flags_b), .cnt_val(cnt_val),
  .err_pulse_o(err_pulse_o), .trig_pulse_o(trig_pulse_o),
  .pend_raw_o(pend_raw_o), .pend_err_o(pend_err_o),
  .pend_trig_o(pend_trig_o), .lim_reached_o(lim_reached_o)
);

// File: tb/err_event_monitor_test.sv
module err_event_monitor_test;

  localparam logic [31:0] EMA = 32'h01FF_E000;
  localparam logic [19:0] EMB = 20'hE_087C;

  logic        clk;
  logic        rst_n;
  logic [31:0] evt_a;
  logic [19:0] evt_b;
  logic [3:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        ep, tp, praw, perr, ptrig, lreach;

  int checks;
  int fails;
  bit done;

  err_event_monitor uut (
    .clk(clk), .rst_n(rst_n), .evt_a_i(evt_a), .evt_b_i(evt_b),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .err_pulse_o(ep), .trig_pulse_o(tp),
    .pend_raw_o(praw), .pend_err_o(perr), .pend_trig_o(ptrig),
    .lim_reached_o(lreach)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; evt_a = '0; evt_b = '0; we = 1'b0; wdata = '0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // event for one cycle; returns at the negedge where the pulses are visible
  task automatic fire(input logic [31:0] a, input logic [19:0] b);
    @(negedge clk);
    evt_a = a; evt_b = b;
    @(negedge clk);
    evt_a = '0; evt_b = '0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    checks = 0; fails = 0; done = 0;

    // R4 reset state, R9 address map
    do_reset();
    expect_reg(4'd0, 32'h0, "R4 flags A");
    expect_reg(4'd1, 32'h0, "R4 flags B");
    expect_reg(4'd2, EMA, "R4 emask A");
    expect_reg(4'd3, {12'h0, EMB}, "R4 emask B");
    expect_reg(4'd4, EMA, "R4 tmask A");
    expect_reg(4'd5, {12'h0, EMB}, "R4 tmask B");
    expect_reg(4'd6, 32'h0, "R4 count");
    expect_reg(4'd7, 32'hF, "R4 limit");
    expect_reg(4'd8, 32'h0, "R4 status");
    chk(!ep && !tp, "R4 pulses idle", {30'h0, tp, ep}, 32'h0);
    for (int a = 9; a < 16; a++) expect_reg(4'(a), 32'h0, "R9 unused address");

    // R1 R2 R3 R5 R6: per-bit sweep over both groups with default masks
    for (int i = 0; i < 52; i++) begin
      logic [31:0] ba;
      logic [19:0] bb;
      bit m;
      do_reset();
      ba = (i < 32) ? (32'h1 << i) : 32'h0;
      bb = (i < 32) ? 20'h0 : (20'h1 << (i - 32));
      m  = (i < 32) ? EMA[i] : EMB[i-32];
      fire(ba, bb);
      chk(ep == !m, "R2 sweep error pulse", {31'h0, ep}, {31'h0, !m});
      chk(tp == !m, "R3 sweep trigger pulse", {31'h0, tp}, {31'h0, !m});
      expect_reg(4'd0, ba, "R1 sweep flags A");
      expect_reg(4'd1, {12'h0, bb}, "R1 sweep flags B");
      @(negedge clk);
      chk(!ep && !tp, "R2 pulse one cycle", {30'h0, tp, ep}, 32'h0);
      expect_reg(4'd6, {31'h0, !m}, "R6 sweep count");
      expect_reg(4'd8, {28'h0, 1'b0, !m, !m, 1'b1}, "R5 sweep status");
    end

    // R3 masks independent
    do_reset();
    wr(4'd2, 32'h0);
    wr(4'd4, 32'hFFFF_FFFF);
    fire(32'h20, 20'h0);
    chk(ep && !tp, "R3 err open trig closed", {30'h0, tp, ep}, 32'h1);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0);
    fire(32'h20, 20'h0);
    chk(!ep && tp, "R3 err closed trig open", {30'h0, tp, ep}, 32'h2);
    expect_reg(4'd6, 32'h1, "R6 count only error-mask hits");

    // R2 R6 simultaneous events: single pulse, single increment
    do_reset();
    fire(32'h0000_00FF, 20'h00003);
    chk(ep, "R2 multi-bit pulse", {31'h0, ep}, 32'h1);
    @(negedge clk);
    chk(!ep, "R2 multi-bit single pulse", {31'h0, ep}, 32'h0);
    expect_reg(4'd6, 32'h1, "R6 multi-bit one increment");
    // back-to-back cycles
    @(negedge clk); evt_a = 32'h1;
    @(negedge clk);
    chk(ep, "R2 back-to-back first", {31'h0, ep}, 32'h1);
    @(negedge clk); evt_a = '0;
    chk(ep, "R2 back-to-back second", {31'h0, ep}, 32'h1);
    expect_reg(4'd6, 32'h3, "R6 back-to-back count");

    // R1 R6 writes to read-only registers ignored
    wr(4'd0, 32'h0);
    wr(4'd1, 32'hF_FFFF);
    wr(4'd6, 32'h1234);
    wr(4'd8, 32'h0);
    expect_reg(4'd0, 32'h0000_00FF, "R1 flags A write ignored");
    expect_reg(4'd1, 32'h3, "R1 flags B write ignored");
    expect_reg(4'd6, 32'h3, "R6 count write ignored");
    expect_reg(4'd8, 32'h7, "R5 status write ignored");

    // R5 unmasking exposes a sticky flag at once
    do_reset();
    fire(32'h0000_2000, 20'h0);
    chk(!ep && praw && !perr, "R5 masked flag", {29'h0, perr, praw, ep}, 32'h2);
    wr(4'd2, EMA & ~32'h0000_2000);
    chk(perr && !ptrig, "R5 unmask exposes", {30'h0, ptrig, perr}, 32'h1);
    chk(!ep, "R2 unmask no pulse", {31'h0, ep}, 32'h0);
    expect_reg(4'd6, 32'h0, "R6 unmask no count");

    // R8 same-cycle mask write and event
    do_reset();
    @(negedge clk);
    evt_a = 32'h1; addr = 4'd2; wdata = 32'h1; we = 1'b1;
    @(negedge clk);
    evt_a = '0; we = 1'b0;
    chk(ep, "R8 old mask open", {31'h0, ep}, 32'h1);
    fire(32'h1, 20'h0);
    chk(!ep, "R8 new mask closed", {31'h0, ep}, 32'h0);
    @(negedge clk);
    evt_b = 20'h4; addr = 4'd3; wdata = 32'h0; we = 1'b1;
    @(negedge clk);
    evt_b = '0; we = 1'b0;
    chk(!ep, "R8 old mask closed", {31'h0, ep}, 32'h0);
    fire(32'h0, 20'h4);
    chk(ep, "R8 new mask open", {31'h0, ep}, 32'h1);
    expect_reg(4'd6, 32'h2, "R8 count");

    // R7 limit
    do_reset();
    wr(4'd7, 32'hFFFF_FFF3);
    expect_reg(4'd7, 32'h3, "R7 limit width");
    fire(32'h1, 20'h0);
    fire(32'h1, 20'h0);
    @(negedge clk);
    chk(!lreach, "R7 below limit", {31'h0, lreach}, 32'h0);
    fire(32'h1, 20'h0);
    @(negedge clk);
    chk(lreach, "R7 at limit", {31'h0, lreach}, 32'h1);
    expect_reg(4'd8, 32'hF, "R7 status bit 3");
    wr(4'd7, 32'hF);
    @(negedge clk);
    chk(lreach, "R7 sticky after raise", {31'h0, lreach}, 32'h1);

    do_reset();
    wr(4'd7, 32'h0);
    @(negedge clk);
    chk(!lreach, "R7 zero limit zero count", {31'h0, lreach}, 32'h0);
    fire(32'h1, 20'h0);
    @(negedge clk);
    chk(lreach, "R7 zero limit first error", {31'h0, lreach}, 32'h1);

    do_reset();
    for (int k = 0; k < 5; k++) fire(32'h1, 20'h0);
    @(negedge clk);
    chk(!lreach, "R7 five under fifteen", {31'h0, lreach}, 32'h0);
    wr(4'd7, 32'h2);
    @(negedge clk);
    chk(lreach, "R7 lowered limit", {31'h0, lreach}, 32'h1);

    // R6 saturation
    do_reset();
    @(negedge clk);
    evt_a = 32'h1;
    repeat (65540) @(negedge clk);
    chk(ep, "R6 pulse at saturation", {31'h0, ep}, 32'h1);
    evt_a = '0;
    expect_reg(4'd6, 32'h0000_FFFF, "R6 saturated count");
    fire(32'h1, 20'h0);
    expect_reg(4'd6, 32'h0000_FFFF, "R6 stays saturated");
    chk(lreach, "R7 reached when saturated", {31'h0, lreach}, 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule